// File: doc/BRIEF.md
# Parallel host command decoder

This block sits at the host-facing edge of a graphic LCD controller. A host processor drives an 8-bit bus together with a chip enable, a data/command select, a read/write line and a strobe. The strobe is brought into the block's clock domain and its falling edge marks one transfer. Each transfer is sorted into one of three kinds: a display-data access, which is passed on to the display RAM controller as a one-cycle write or read pulse; a command write, which updates the configuration register file; or a command read, which returns the contrast level.

Command bytes use a prefix code of variable length. The leading bits select the register, and the bits that remain carry its value. The register file holds the RAM page, a column address with one saved copy, a 16-level contrast value that can be loaded or stepped, the icon contrast, the vertical scroll, four static icon enables, a temperature grade and a vector of single-bit power and mapping flags. Every register has a fixed value after reset. The analog parts that these flags enable belong to other blocks.

Top module: `lcd_host_decoder`

## Requirements
- R1: A transfer is taken on a falling edge of `bus_stb` while `bus_ce` is high. With `bus_dc`=1 and `bus_rw`=0 it produces exactly one `ram_wr` pulse with `ram_wdata` equal to the bus byte. With `bus_dc`=1 and `bus_rw`=1 it produces exactly one `ram_rd` pulse, and while `bus_ce` and `bus_rw` are high `bus_doe` is 1 and `bus_dout` carries `ram_rdata`. A strobe with `bus_ce` low produces no pulse and changes no register.
- R2: After `rst_n` is low: page code 0, icon level 2'b10, contrast 0, scroll 0, column 0, saved column 0, all icons off, temperature grade 0, every flag 0 and icon mode 0.
- R3: Command 8'b00000ppp loads `page_addr` with ppp when ppp is 0 to 4 (pages one to five). Codes 5 to 7 leave the page unchanged.
- R4: Command 8'b000011ll loads `icon_level` with ll.
- R5: Command 8'b0001cccc loads `contrast`. A command read (`bus_dc`=0, `bus_rw`=1, `bus_ce`=1) with `bus_din[7:4]`=4'b0001 drives {4'b0000, contrast} on `bus_dout`. Any other upper nibble gives 8'h00.
- R6: Command 8'b0111000s steps `contrast` up by one when s=1 and down by one when s=0. The step wraps from 15 to 0 and from 0 to 15.
- R7: Command 8'b010sssss loads `scroll` with sssss.
- R8: Command 8'b01100iiv sets `icon_on[ii]` to v and leaves the other icons unchanged.
- R9: Command 8'b1ccccccc loads `col_addr`. Command 8'b0011010s with s=1 saves `col_addr` into a private copy. With s=0 it loads `col_addr` from that copy.
- R10: A command of the form {7-bit opcode, v} sets one bit of `cfg_flags` to v: 0010000→bit0 (pump select), 0010001→bit1 (column mirror), 0010010→bit2 (row mirror), 0010100→bit3 (display on), 0010101→bit4 (converter on), 0010110→bit5 (regulator on), 0010111→bit6 (divider on), 0011000→bit7 (software contrast on), 0011001→bit8 (fast clock), 0011100→bit9 (one-fifth bias), 0011110→bit10 (icon line), 0110100→bit11 (16-row duty), 0110101→bit12 (current-reduction mode).
- R11: Command 8'b00111110 sets `icon_mode` to 1. Any command 8'b0011110v clears `icon_mode` in addition to its R10 effect.
- R12: Command 8'b011011gg loads `temp_grade` with gg.
- R13: Bytes 0010011x, 0011011x, 0011101x, 00111111, 000010xx and 0111xxxx other than 0111000x change no register. Neither does any data access or command read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Chip enable, high to accept transfers |
| bus_dc | input | 1 | 1 = display data, 0 = command |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | Transfer strobe, taken on its falling edge |
| bus_din | input | 8 | Byte driven by the host |
| bus_dout | output | 8 | Byte returned to the host on reads |
| bus_doe | output | 1 | Output enable for the bus pad |
| ram_rdata | input | 8 | Byte supplied by the display RAM controller |
| ram_wr | output | 1 | One-cycle display-data write pulse |
| ram_rd | output | 1 | One-cycle display-data read pulse |
| ram_wdata | output | 8 | Byte to write into display RAM |
| page_addr | output | 3 | RAM page code |
| icon_level | output | 2 | Icon contrast level |
| contrast | output | 4 | Contrast level |
| scroll | output | 5 | Vertical scroll value |
| col_addr | output | 7 | Column address |
| icon_on | output | 4 | Static icon enables |
| temp_grade | output | 2 | Temperature-coefficient grade |
| cfg_flags | output | 13 | Single-bit settings, bit positions as in R10 |
| icon_mode | output | 1 | Low-power icon display mode |

## Verification
A wrong decode leaves a register at the wrong value. That value appears directly on its output port a few clock cycles after the strobe falls and stays there until the next command. For this reason the bench compares the whole register state after every one of the 256 command bytes, and a misrouted prefix is caught at the byte that causes it. A fault in the contrast arithmetic is visible only at the wrap points, so those points are driven explicitly. A fault in the save copy stays hidden until a restore brings it out, so a restore is checked after a new column has been loaded.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_PAGE,
      OP_ICON_LVL,
      OP_CON_LOAD,
      OP_CON_STEP,
      OP_SCROLL,
      OP_ICON,
      OP_COLUMN,
      OP_COL_SAVE,
      OP_TEMP,
      OP_FLAG,
      OP_ICON_MODE
   } op_e;

   localparam int NFLAG      = 13;
   localparam int FLAG_IDX_W = 4;

   localparam int FL_PUMP     = 0;
   localparam int FL_COLMIR   = 1;
   localparam int FL_ROWMIR   = 2;
   localparam int FL_DISP     = 3;
   localparam int FL_CONV     = 4;
   localparam int FL_REG      = 5;
   localparam int FL_DIV      = 6;
   localparam int FL_SWCON    = 7;
   localparam int FL_FASTCLK  = 8;
   localparam int FL_BIAS5    = 9;
   localparam int FL_ICONLINE = 10;
   localparam int FL_DUTY16   = 11;
   localparam int FL_IDDRED   = 12;

   typedef struct packed {
      op_e                   op;
      logic [6:0]            arg;
      logic [FLAG_IDX_W-1:0] flag_idx;
   } cmd_t;

endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_async,
   output logic stb_fall
);

   localparam int SH_W = STAGES + 1;

   logic [SH_W-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lcd_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], stb_async};
   end

   assign stb_fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];

endmodule

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
   import lcd_host_pkg::*;
#(
   parameter int NPAGE = 5
) (
   input  logic [7:0] cmd_byte,
   output cmd_t       cmd
);

   always_comb begin
      cmd.op       = OP_NONE;
      cmd.arg      = cmd_byte[6:0];
      cmd.flag_idx = '0;
      casez (cmd_byte)
         8'b1???????: cmd.op = OP_COLUMN;
         8'b010?????: cmd.op = OP_SCROLL;
         8'b01100???: cmd.op = OP_ICON;
         8'b0111000?: cmd.op = OP_CON_STEP;
         8'b011011??: cmd.op = OP_TEMP;
         8'b0110100?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_DUTY16);   end
         8'b0110101?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_IDDRED);   end
         8'b0001????: cmd.op = OP_CON_LOAD;
         8'b00000???: if (int'(cmd_byte[2:0]) < NPAGE) cmd.op = OP_PAGE;
         8'b000011??: cmd.op = OP_ICON_LVL;
         8'b0010000?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_PUMP);     end
         8'b0010001?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_COLMIR);   end
         8'b0010010?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_ROWMIR);   end
         8'b0010100?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_DISP);     end
         8'b0010101?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_CONV);     end
         8'b0010110?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_REG);      end
         8'b0010111?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_DIV);      end
         8'b0011000?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_SWCON);    end
         8'b0011001?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_FASTCLK);  end
         8'b0011010?: cmd.op = OP_COL_SAVE;
         8'b0011100?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_BIAS5);    end
         8'b0011110?: begin cmd.op = OP_FLAG; cmd.flag_idx = FLAG_IDX_W'(FL_ICONLINE); end
         8'b00111110: cmd.op = OP_ICON_MODE;
         default:     cmd.op = OP_NONE;
      endcase
   end

endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
   import lcd_host_pkg::*;
#(
   parameter int PAGE_W   = 3,
   parameter int CON_W    = 4,
   parameter int SCROLL_W = 5,
   parameter int COL_W    = 7,
   parameter int ICON_N   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_we,
   input  cmd_t                cmd,
   output logic [PAGE_W-1:0]   page_addr,
   output logic [1:0]          icon_level,
   output logic [CON_W-1:0]    contrast,
   output logic [SCROLL_W-1:0] scroll,
   output logic [COL_W-1:0]    col_addr,
   output logic [ICON_N-1:0]   icon_on,
   output logic [1:0]          temp_grade,
   output logic [NFLAG-1:0]    cfg_flags,
   output logic                icon_mode
);

   localparam logic [1:0] ICON_LVL_RST = 2'b10;

   logic [COL_W-1:0] col_save_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              page_addr <= '0;
      else if (cmd_we && cmd.op == OP_PAGE)    page_addr <= cmd.arg[PAGE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              icon_level <= ICON_LVL_RST;
      else if (cmd_we && cmd.op == OP_ICON_LVL) icon_level <= cmd.arg[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) contrast <= '0;
      else if (cmd_we) begin
         if (cmd.op == OP_CON_LOAD)      contrast <= cmd.arg[CON_W-1:0];
         else if (cmd.op == OP_CON_STEP) contrast <= cmd.arg[0] ? contrast + 1'b1
                                                                : contrast - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              scroll <= '0;
      else if (cmd_we && cmd.op == OP_SCROLL)  scroll <= cmd.arg[SCROLL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_addr   <= '0;
         col_save_q <= '0;
      end else if (cmd_we) begin
         if (cmd.op == OP_COLUMN) col_addr <= cmd.arg[COL_W-1:0];
         else if (cmd.op == OP_COL_SAVE) begin
            if (cmd.arg[0]) col_save_q <= col_addr;
            else            col_addr   <= col_save_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           temp_grade <= '0;
      else if (cmd_we && cmd.op == OP_TEMP) temp_grade <= cmd.arg[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) icon_mode <= 1'b0;
      else if (cmd_we) begin
         if (cmd.op == OP_ICON_MODE) icon_mode <= 1'b1;
         else if (cmd.op == OP_FLAG && cmd.flag_idx == FLAG_IDX_W'(FL_ICONLINE))
            icon_mode <= 1'b0;
      end
   end

   generate
      for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_flags[gi] <= 1'b0;
            else if (cmd_we && cmd.op == OP_FLAG && cmd.flag_idx == FLAG_IDX_W'(gi))
               cfg_flags[gi] <= cmd.arg[0];
         end
      end
      for (genvar gk = 0; gk < ICON_N; gk++) begin : g_icon
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) icon_on[gk] <= 1'b0;
            else if (cmd_we && cmd.op == OP_ICON && cmd.arg[2:1] == 2'(gk))
               icon_on[gk] <= cmd.arg[0];
         end
      end
   endgenerate

endmodule

// File: rtl/lcd_host_decoder.sv
module lcd_host_decoder
   import lcd_host_pkg::*;
#(
   parameter int BUS_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NPAGE      = 5,
   parameter int CON_W      = 4,
   parameter int SCROLL_W   = 5,
   parameter int COL_W      = 7,
   parameter int ICON_N     = 4,
   localparam int PAGE_W    = $clog2(NPAGE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_ce,
   input  logic                bus_dc,
   input  logic                bus_rw,
   input  logic                bus_stb,
   input  logic [BUS_W-1:0]    bus_din,
   output logic [BUS_W-1:0]    bus_dout,
   output logic                bus_doe,
   input  logic [BUS_W-1:0]    ram_rdata,
   output logic                ram_wr,
   output logic                ram_rd,
   output logic [BUS_W-1:0]    ram_wdata,
   output logic [PAGE_W-1:0]   page_addr,
   output logic [1:0]          icon_level,
   output logic [CON_W-1:0]    contrast,
   output logic [SCROLL_W-1:0] scroll,
   output logic [COL_W-1:0]    col_addr,
   output logic [ICON_N-1:0]   icon_on,
   output logic [1:0]          temp_grade,
   output logic [NFLAG-1:0]    cfg_flags,
   output logic                icon_mode
);

   localparam logic [3:0] RD_CON_TAG = 4'b0001;

   generate
      if (BUS_W != 8)                 begin : g_bad_bus    $error("BUS_W must be 8");           end
      if (NPAGE < 2 || NPAGE > 8)     begin : g_bad_page   $error("NPAGE must be 2..8");        end
      if (CON_W < 1 || CON_W > 4)     begin : g_bad_con    $error("CON_W must be 1..4");        end
      if (SCROLL_W < 1 || SCROLL_W > 5) begin : g_bad_scr  $error("SCROLL_W must be 1..5");     end
      if (COL_W < 1 || COL_W > 7)     begin : g_bad_col    $error("COL_W must be 1..7");        end
      if (ICON_N < 1 || ICON_N > 4)   begin : g_bad_icon   $error("ICON_N must be 1..4");       end
   endgenerate

   logic stb_fall;
   logic xfer;
   logic cmd_we;
   cmd_t cmd;

   lcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_async (bus_stb),
      .stb_fall  (stb_fall)
   );

   assign xfer   = stb_fall & bus_ce;
   assign cmd_we = xfer & ~bus_dc & ~bus_rw;
   assign ram_wr = xfer &  bus_dc & ~bus_rw;
   assign ram_rd = xfer &  bus_dc &  bus_rw;
   assign ram_wdata = bus_din;

   lcd_cmd_decode #(.NPAGE(NPAGE)) u_dec (
      .cmd_byte (bus_din),
      .cmd      (cmd)
   );

   lcd_cfg_regs #(
      .PAGE_W   (PAGE_W),
      .CON_W    (CON_W),
      .SCROLL_W (SCROLL_W),
      .COL_W    (COL_W),
      .ICON_N   (ICON_N)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (cmd_we),
      .cmd        (cmd),
      .page_addr  (page_addr),
      .icon_level (icon_level),
      .contrast   (contrast),
      .scroll     (scroll),
      .col_addr   (col_addr),
      .icon_on    (icon_on),
      .temp_grade (temp_grade),
      .cfg_flags  (cfg_flags),
      .icon_mode  (icon_mode)
   );

   always_comb begin
      bus_doe = bus_ce & bus_rw;
      if (bus_dc)                          bus_dout = ram_rdata;
      else if (bus_din[7:4] == RD_CON_TAG) bus_dout = BUS_W'(contrast);
      else                                 bus_dout = '0;
   end

endmodule

// File: rtl/lcd_host_checker.sv
module lcd_host_checker #(
   parameter int NPAGE    = 5,
   parameter int PAGE_W   = 3,
   parameter int CON_W    = 4,
   parameter int SCROLL_W = 5,
   parameter int COL_W    = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_ce,
   input logic                xfer,
   input logic                ram_wr,
   input logic                ram_rd,
   input logic [PAGE_W-1:0]   page_addr,
   input logic [1:0]          icon_level,
   input logic [CON_W-1:0]    contrast,
   input logic [SCROLL_W-1:0] scroll,
   input logic [COL_W-1:0]    col_addr
);

   // R1: no data pulse without chip enable
   p_ce_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ce |-> (!ram_wr && !ram_rd));

   // R1: write and read pulses never coincide
   p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_wr && ram_rd));

   // R1: one transfer gives a single-cycle pulse
   p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> !xfer);

   // R3: page code stays within the implemented pages
   p_page_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(page_addr) < NPAGE);

   // R2: values right after reset release
   p_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (contrast == '0 && page_addr == '0 &&
                        icon_level == 2'b10 && scroll == '0 && col_addr == '0));

   // R13: registers hold when no transfer is taken
   p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> ($stable(contrast) && $stable(page_addr) && $stable(scroll) &&
                 $stable(col_addr) && $stable(icon_level)));

endmodule

bind lcd_host_decoder lcd_host_checker #(
   .NPAGE    (NPAGE),
   .PAGE_W   (PAGE_W),
   .CON_W    (CON_W),
   .SCROLL_W (SCROLL_W),
   .COL_W    (COL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_ce     (bus_ce),
   .xfer       (xfer),
   .ram_wr     (ram_wr),
   .ram_rd     (ram_rd),
   .page_addr  (page_addr),
   .icon_level (icon_level),
   .contrast   (contrast),
   .scroll     (scroll),
   .col_addr   (col_addr)
);

// File: tb/lcd_host_decoder_bench.sv
module lcd_host_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_ce = 1'b0;
   logic        bus_dc = 1'b0;
   logic        bus_rw = 1'b0;
   logic        bus_stb = 1'b0;
   logic [7:0]  bus_din = 8'h00;
   logic [7:0]  bus_dout;
   logic        bus_doe;
   logic [7:0]  ram_rdata = 8'h00;
   logic        ram_wr;
   logic        ram_rd;
   logic [7:0]  ram_wdata;
   logic [2:0]  page_addr;
   logic [1:0]  icon_level;
   logic [3:0]  contrast;
   logic [4:0]  scroll;
   logic [6:0]  col_addr;
   logic [3:0]  icon_on;
   logic [1:0]  temp_grade;
   logic [12:0] cfg_flags;
   logic        icon_mode;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   logic [7:0] last_wdata = 8'h00;

   // expected state
   logic [2:0]  e_page;
   logic [1:0]  e_icl;
   logic [3:0]  e_con;
   logic [4:0]  e_scr;
   logic [6:0]  e_col;
   logic [6:0]  e_save;
   logic [3:0]  e_icon;
   logic [1:0]  e_tg;
   logic [12:0] e_flags;
   logic        e_imode;

   always #2 clk = ~clk;

   lcd_host_decoder u_lcd_host_decoder (
      .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_dc(bus_dc), .bus_rw(bus_rw),
      .bus_stb(bus_stb), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .ram_rdata(ram_rdata), .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_wdata(ram_wdata),
      .page_addr(page_addr), .icon_level(icon_level), .contrast(contrast),
      .scroll(scroll), .col_addr(col_addr), .icon_on(icon_on), .temp_grade(temp_grade),
      .cfg_flags(cfg_flags), .icon_mode(icon_mode)
   );

   always @(negedge clk) begin
      if (ram_wr) begin wr_cnt++; last_wdata = ram_wdata; end
      if (ram_rd) rd_cnt++;
   end

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [40:0] got_state();
      return {page_addr, icon_level, contrast, scroll, col_addr, icon_on,
              temp_grade, cfg_flags, icon_mode};
   endfunction

   function automatic logic [40:0] exp_state();
      return {e_page, e_icl, e_con, e_scr, e_col, e_icon, e_tg, e_flags, e_imode};
   endfunction

   task automatic model_reset();
      e_page = 3'd0; e_icl = 2'b10; e_con = 4'd0; e_scr = 5'd0; e_col = 7'd0;
      e_save = 7'd0; e_icon = 4'd0; e_tg = 2'd0; e_flags = 13'd0; e_imode = 1'b0;
   endtask

   // independent model of the command map, returns the requirement tag
   task automatic model_cmd(input logic [7:0] b, output string tag);
      int sub;
      tag = "R13";
      if (b[7]) begin e_col = b[6:0]; tag = "R9"; end
      else if (b[7:5] == 3'b010) begin e_scr = b[4:0]; tag = "R7"; end
      else if (b[7:3] == 5'b01100) begin e_icon[b[2:1]] = b[0]; tag = "R8"; end
      else if (b[7:1] == 7'b0111000) begin
         e_con = b[0] ? e_con + 4'd1 : e_con - 4'd1; tag = "R6";
      end
      else if (b[7:2] == 6'b011011) begin e_tg = b[1:0]; tag = "R12"; end
      else if (b[7:1] == 7'b0110100) begin e_flags[11] = b[0]; tag = "R10"; end
      else if (b[7:1] == 7'b0110101) begin e_flags[12] = b[0]; tag = "R10"; end
      else if (b[7:4] == 4'b0001) begin e_con = b[3:0]; tag = "R5"; end
      else if (b[7:3] == 5'b00000) begin
         if (b[2:0] < 3'd5) e_page = b[2:0];
         tag = "R3";
      end
      else if (b[7:2] == 6'b000011) begin e_icl = b[1:0]; tag = "R4"; end
      else if (b[7:5] == 3'b001) begin
         sub = int'(b[4:1]);
         case (sub)
            0, 1, 2: begin e_flags[sub] = b[0]; tag = "R10"; end
            4, 5, 6, 7, 8, 9: begin e_flags[sub-1] = b[0]; tag = "R10"; end
            10: begin
               if (b[0]) e_save = e_col; else e_col = e_save;
               tag = "R9";
            end
            12: begin e_flags[9] = b[0]; tag = "R10"; end
            14: begin e_flags[10] = b[0]; e_imode = 1'b0; tag = "R11"; end
            15: if (!b[0]) begin e_imode = 1'b1; tag = "R11"; end
            default: tag = "R13";
         endcase
      end
   endtask

   task automatic bus_xfer(input logic ce, input logic dc, input logic rw,
                           input logic [7:0] d);
      @(negedge clk);
      bus_ce = ce; bus_dc = dc; bus_rw = rw; bus_din = d; bus_stb = 1'b1;
      repeat (3) @(negedge clk);
      bus_stb = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic cmd_write(input logic [7:0] b, output string tag);
      bus_xfer(1'b1, 1'b0, 1'b0, b);
      model_cmd(b, tag);
   endtask

   task automatic check_state(input string tag);
      chk(got_state() === exp_state(), tag, 64'(got_state()), 64'(exp_state()));
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      string tag;
      int w0, r0;
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 reset values
      check_state("R2 reset state");

      // R1 data write
      w0 = wr_cnt; r0 = rd_cnt;
      bus_xfer(1'b1, 1'b1, 1'b0, 8'hA5);
      chk(wr_cnt == w0 + 1, "R1 write pulse count", 64'(wr_cnt - w0), 64'd1);
      chk(last_wdata == 8'hA5, "R1 write data", 64'(last_wdata), 64'hA5);
      chk(rd_cnt == r0, "R1 no read pulse on write", 64'(rd_cnt - r0), 64'd0);
      check_state("R13 data write leaves registers");

      // R1 chip enable low: nothing
      w0 = wr_cnt;
      bus_xfer(1'b0, 1'b1, 1'b0, 8'h5A);
      chk(wr_cnt == w0, "R1 ce low no pulse", 64'(wr_cnt - w0), 64'd0);
      bus_xfer(1'b0, 1'b0, 1'b0, 8'h1F);
      check_state("R1 ce low command ignored");

      // R1 data read
      ram_rdata = 8'h3C;
      r0 = rd_cnt;
      @(negedge clk);
      bus_ce = 1'b1; bus_dc = 1'b1; bus_rw = 1'b1; bus_din = 8'h00;
      #1;
      chk(bus_doe == 1'b1, "R1 read output enable", 64'(bus_doe), 64'd1);
      chk(bus_dout == 8'h3C, "R1 read data", 64'(bus_dout), 64'h3C);
      bus_xfer(1'b1, 1'b1, 1'b1, 8'h00);
      chk(rd_cnt == r0 + 1, "R1 read pulse count", 64'(rd_cnt - r0), 64'd1);

      // exhaustive command sweep
      for (int b = 0; b < 256; b++) begin
         cmd_write(8'(b), tag);
         check_state($sformatf("%s byte %02h", tag, b));
      end

      // R5 contrast load and readback
      for (int c = 0; c < 16; c++) begin
         cmd_write(8'h10 | 8'(c), tag);
         @(negedge clk);
         bus_ce = 1'b1; bus_dc = 1'b0; bus_rw = 1'b1; bus_din = 8'h10;
         #1;
         chk(bus_dout == 8'(c), "R5 contrast readback", 64'(bus_dout), 64'(c));
      end
      bus_din = 8'h20;
      #1;
      chk(bus_dout == 8'h00, "R5 other nibble reads zero", 64'(bus_dout), 64'h00);
      bus_xfer(1'b1, 1'b0, 1'b1, 8'h10);
      check_state("R13 command read leaves registers");

      // R6 wrap points
      cmd_write(8'h1F, tag);
      cmd_write(8'h71, tag);
      chk(contrast == 4'd0, "R6 step up wraps 15 to 0", 64'(contrast), 64'd0);
      cmd_write(8'h70, tag);
      chk(contrast == 4'd15, "R6 step down wraps 0 to 15", 64'(contrast), 64'd15);
      cmd_write(8'h70, tag);
      chk(contrast == 4'd14, "R6 step down", 64'(contrast), 64'd14);

      // R3 invalid page code
      cmd_write(8'h03, tag);
      cmd_write(8'h06, tag);
      chk(page_addr == 3'd3, "R3 page code 6 ignored", 64'(page_addr), 64'd3);

      // R9 save and restore
      cmd_write(8'h80 | 8'd45, tag);
      cmd_write(8'h35, tag);
      cmd_write(8'h80 | 8'd9, tag);
      cmd_write(8'h34, tag);
      chk(col_addr == 7'd45, "R9 restore column", 64'(col_addr), 64'd45);

      // R11 icon mode set and cleared
      cmd_write(8'h3E, tag);
      chk(icon_mode == 1'b1, "R11 icon mode set", 64'(icon_mode), 64'd1);
      cmd_write(8'h3D, tag);
      chk(icon_mode == 1'b0, "R11 icon mode cleared", 64'(icon_mode), 64'd0);
      check_state("R10 icon line flag");

      // R8 single icon, R4, R7, R12
      cmd_write(8'h65, tag);
      chk(icon_on[2] == 1'b1, "R8 icon 2 on", 64'(icon_on), 64'(e_icon));
      cmd_write(8'h0D, tag);
      chk(icon_level == 2'b01, "R4 icon level", 64'(icon_level), 64'd1);
      cmd_write(8'h5B, tag);
      chk(scroll == 5'd27, "R7 scroll", 64'(scroll), 64'd27);
      cmd_write(8'h6E, tag);
      chk(temp_grade == 2'b10, "R12 temperature grade", 64'(temp_grade), 64'd2);
      check_state("R2 final state");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule